// File: doc/BRIEF.md
# Timer Compare-Match Output Channel

This block is one output-compare channel that sits beside a 16-bit timer counter. It holds a compare value and a two-bit output action field. On every timer tick it checks the running count against the compare value. Each qualified match raises an interrupt flag and moves an internal output level. How the level moves depends on the waveform family, the count direction and the wrap indication. The counter, the prescaler and the capture logic live outside the block, so the count, the tick enable, the direction and the TOP-to-BOTTOM wrap all arrive as inputs.

The match gate is a two-state machine. In `GATE_OPEN`, a tick whose count equals the compare value is a qualified match. A software count write takes the gate from `GATE_OPEN` to `GATE_HELD`, and a match in that same cycle is also dropped. The gate stays in `GATE_HELD` through further writes and through cycles with no tick. It goes back from `GATE_HELD` to `GATE_OPEN` on the first tick without a write, and the match of that tick is suppressed.

The output level is a second machine with the states `LVL_LOW` and `LVL_HIGH`. A set action moves it from `LVL_LOW` to `LVL_HIGH`, a clear action moves it from `LVL_HIGH` to `LVL_LOW`, and a toggle moves it either way. A pin multiplexer drives the pin from this level or from the port data bit, and the port direction bit gates the result.

Top module: `ocu_compare_channel`

## Requirements
- R1: After reset `oc_bit` and `irq_flag` are 0. The output level keeps its value when `wave_mode` changes.
- R2: When `count_wr` is high, any match in that cycle is dropped. The match on the next cycle with `tick` high is also dropped, even if many tick-free cycles pass first.
- R3: An action field of 00 leaves `oc_bit` unchanged on matches, on wraps and on force strobes, in every waveform mode.
- R4: `wave_mode` 00 or 11 selects the non-PWM family. In that family a match toggles the level for action 01, clears it for 10 and sets it for 11.
- R5: In the non-PWM family, `force_strobe` applies the selected action in that cycle with no match and never sets `irq_flag`. In the PWM families (`wave_mode` 01 or 10) the strobe has no effect.
- R6: `wave_mode` 01 is single-slope PWM. With action 10, a match clears the level and a tick with `cnt_wrap` high sets it. Action 11 does the opposite. When both happen in the same tick, the wrap action wins.
- R7: In single-slope PWM with TOP = 3 and action 10, a compare value equal to TOP holds the level at 1. A compare value of 0 gives a high pulse one tick long in every four ticks.
- R8: `wave_mode` 10 is dual-slope PWM. With action 10, a match clears the level while counting up (`cnt_down` = 0) and sets it while counting down. Action 11 does the opposite.
- R9: A qualified match sets `irq_flag` at the same clock edge. A set has priority over a clear in the same cycle.
- R10: Pulsing `flag_clr` high (a write of 1) clears `irq_flag` when there is no match in that cycle.
- R11: `pin_oe` follows `port_dir`. `pin_out` is 0 when `port_dir` is 0. Otherwise `pin_out` is `oc_bit` if the action field is nonzero, and `port_data` if it is zero.
- R12: Writes to the compare value and to the action field take effect on the next clock cycle, with no buffering to a period boundary.
- R13: Action 01 has no effect in either PWM family.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer clock enable for this cycle |
| count | input | 16 | Running counter value |
| count_wr | input | 1 | Software write to the counter this cycle |
| cmp_wr | input | 1 | Load `cmp_wdata` into the compare value |
| cmp_wdata | input | 16 | New compare value |
| om_wr | input | 1 | Load `om_wdata` into the action field |
| om_wdata | input | 2 | New action field |
| wave_mode | input | 2 | Waveform family: 00/11 non-PWM, 01 single-slope, 10 dual-slope |
| cnt_down | input | 1 | Counter is counting down |
| cnt_wrap | input | 1 | This tick moves the counter from TOP to BOTTOM |
| force_strobe | input | 1 | Apply the non-PWM action now |
| flag_clr | input | 1 | Write-one clear of the interrupt flag |
| port_data | input | 1 | General port data bit |
| port_dir | input | 1 | Port direction, 1 = output |
| oc_bit | output | 1 | Internal output-compare level |
| irq_flag | output | 1 | Compare interrupt flag |
| pin_out | output | 1 | Pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
Suppose the match gate is left in `GATE_HELD` when it should not be, or is released too early. The first matching tick afterwards then shows the wrong value on `irq_flag`, and in most action settings on `oc_bit` too, one edge later. A wrong output level state appears on `oc_bit` at once and on `pin_out` whenever the override and the direction bit are on. A wrong stored action field shows up at the next match or wrap, and also straight away through the choice of pin source. The bench runs a reference model tick by tick, so any of these faults shows up within one cycle of the stimulus that reveals it.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    localparam int OM_W = 2;

    // waveform family as seen by the action decoder
    typedef enum logic [1:0] {
        WF_PLAIN     = 2'b00,
        WF_SINGLE    = 2'b01,
        WF_DUAL      = 2'b10,
        WF_PLAIN_ALT = 2'b11
    } wave_e;

    // output action field encoding
    typedef enum logic [OM_W-1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_LOW    = 2'b10,
        OM_HIGH   = 2'b11
    } omode_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_CLEAR,
        ACT_SET,
        ACT_TOGGLE
    } act_e;

    // match gate after a software count write
    typedef enum logic {
        GATE_OPEN,
        GATE_HELD
    } gate_e;

    // internal output-compare level
    typedef enum logic {
        LVL_LOW,
        LVL_HIGH
    } level_e;

endpackage

// File: rtl/ocu_cmp_store.sv
module ocu_cmp_store
    import ocu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_wr,
    input  logic [W-1:0]        cmp_wdata,
    input  logic                om_wr,
    input  logic [OM_W-1:0]     om_wdata,
    input  logic [W-1:0]        count,
    output logic [OM_W-1:0]     om_q,
    output logic                equal
);

    logic [W-1:0] cmp_q;
    logic [W-1:0] bit_same;

    // compare value: direct load, no period buffering
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= cmp_wdata;
        end
    end

    // action field: takes effect from the next cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            om_q <= OM_OFF;
        end else if (om_wr) begin
            om_q <= om_wdata;
        end
    end

    // per-bit equality, reduced to one match line
    for (genvar i = 0; i < W; i++) begin : g_eq
        assign bit_same[i] = ~(cmp_q[i] ^ count[i]);
    end

    assign equal = &bit_same;

endmodule

// File: rtl/ocu_block_gate.sv
module ocu_block_gate
    import ocu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic count_wr,
    input  logic equal,
    output logic match_ok
);

    gate_e state_q;
    gate_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN: begin
                if (count_wr) begin
                    state_d = GATE_HELD;
                end
            end
            GATE_HELD: begin
                if (count_wr) begin
                    state_d = GATE_HELD;
                end else if (tick) begin
                    state_d = GATE_OPEN;
                end
            end
        endcase
    end

    // outputs: a match counts only when the gate is open and no write is in flight
    always_comb begin
        match_ok = 1'b0;
        unique case (state_q)
            GATE_OPEN: match_ok = tick & equal & ~count_wr;
            GATE_HELD: match_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/ocu_wave_ctl.sv
module ocu_wave_ctl
    import ocu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            match_ok,
    input  logic [1:0]      wave_mode,
    input  logic [OM_W-1:0] om,
    input  logic            cnt_down,
    input  logic            cnt_wrap,
    input  logic            force_strobe,
    input  logic            flag_clr,
    output logic            oc_bit,
    output logic            irq_flag
);

    wave_e  wm;
    omode_e om_e;
    act_e   act;
    logic   wrap_now;
    logic   plain_trig;
    level_e lvl_q;
    level_e lvl_d;

    assign wm         = wave_e'(wave_mode);
    assign om_e       = omode_e'(om);
    assign wrap_now   = tick & cnt_wrap;
    assign plain_trig = match_ok | force_strobe;

    // action decode
    always_comb begin
        act = ACT_NONE;
        unique case (wm)
            WF_SINGLE: begin
                // the wrap edge has priority over a match in the same tick
                if (om_e == OM_LOW) begin
                    if (wrap_now)      act = ACT_SET;
                    else if (match_ok) act = ACT_CLEAR;
                end else if (om_e == OM_HIGH) begin
                    if (wrap_now)      act = ACT_CLEAR;
                    else if (match_ok) act = ACT_SET;
                end
            end
            WF_DUAL: begin
                if (match_ok) begin
                    if (om_e == OM_LOW) begin
                        act = cnt_down ? ACT_SET : ACT_CLEAR;
                    end else if (om_e == OM_HIGH) begin
                        act = cnt_down ? ACT_CLEAR : ACT_SET;
                    end
                end
            end
            WF_PLAIN, WF_PLAIN_ALT: begin
                if (plain_trig) begin
                    unique case (om_e)
                        OM_OFF:    act = ACT_NONE;
                        OM_TOGGLE: act = ACT_TOGGLE;
                        OM_LOW:    act = ACT_CLEAR;
                        OM_HIGH:   act = ACT_SET;
                    endcase
                end
            end
        endcase
    end

    // level state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= LVL_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    // level transitions
    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_LOW: begin
                if (act == ACT_SET || act == ACT_TOGGLE) begin
                    lvl_d = LVL_HIGH;
                end
            end
            LVL_HIGH: begin
                if (act == ACT_CLEAR || act == ACT_TOGGLE) begin
                    lvl_d = LVL_LOW;
                end
            end
        endcase
    end

    // interrupt flag: a match wins over a write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (match_ok) begin
            irq_flag <= 1'b1;
        end else if (flag_clr) begin
            irq_flag <= 1'b0;
        end
    end

    assign oc_bit = (lvl_q == LVL_HIGH);

endmodule

// File: rtl/ocu_pin_mux.sv
module ocu_pin_mux
    import ocu_pkg::*;
(
    input  logic [OM_W-1:0] om,
    input  logic            oc_bit,
    input  logic            port_data,
    input  logic            port_dir,
    output logic            pin_out,
    output logic            pin_oe
);

    logic override;
    logic src;

    assign override = |om;
    assign src      = override ? oc_bit : port_data;
    assign pin_oe   = port_dir;
    assign pin_out  = port_dir & src;

endmodule

// File: rtl/ocu_compare_channel.sv
module ocu_compare_channel
    import ocu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic         count_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         om_wr,
    input  logic [1:0]   om_wdata,
    input  logic [1:0]   wave_mode,
    input  logic         cnt_down,
    input  logic         cnt_wrap,
    input  logic         force_strobe,
    input  logic         flag_clr,
    input  logic         port_data,
    input  logic         port_dir,
    output logic         oc_bit,
    output logic         irq_flag,
    output logic         pin_out,
    output logic         pin_oe
);

    logic [OM_W-1:0] om_q;
    logic            equal;
    logic            match_ok;

    ocu_cmp_store #(.W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .om_wr     (om_wr),
        .om_wdata  (om_wdata),
        .count     (count),
        .om_q      (om_q),
        .equal     (equal)
    );

    ocu_block_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .count_wr (count_wr),
        .equal    (equal),
        .match_ok (match_ok)
    );

    ocu_wave_ctl u_wave (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .match_ok     (match_ok),
        .wave_mode    (wave_mode),
        .om           (om_q),
        .cnt_down     (cnt_down),
        .cnt_wrap     (cnt_wrap),
        .force_strobe (force_strobe),
        .flag_clr     (flag_clr),
        .oc_bit       (oc_bit),
        .irq_flag     (irq_flag)
    );

    ocu_pin_mux u_pin (
        .om        (om_q),
        .oc_bit    (oc_bit),
        .port_data (port_data),
        .port_dir  (port_dir),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

endmodule

// File: rtl/ocu_compare_channel_chk.sv
module ocu_compare_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       count_wr,
    input logic       flag_clr,
    input logic [1:0] wave_mode,
    input logic       cnt_down,
    input logic       port_dir,
    input logic       pin_out,
    input logic       oc_bit,
    input logic       irq_flag,
    input logic       match_ok,
    input logic [1:0] om_q
);

    // R1: reset clears level and flag
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!oc_bit && !irq_flag));

    // R2: a count write cannot raise the flag in its own cycle
    a_r2_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (count_wr && !irq_flag) |=> !irq_flag);

    // R3: action field 00 holds the level
    a_r3_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (om_q == 2'b00) |=> $stable(oc_bit));

    // R5: without a tick nothing, including the force strobe, sets the flag
    a_r5_no_tick_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !irq_flag) |=> !irq_flag);

    // R8: dual-slope, action 10, up-count match clears
    a_r8_dual_up_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode == 2'b10 && om_q == 2'b10 && match_ok && !cnt_down) |=> !oc_bit);

    // R9: a qualified match sets the flag
    a_r9_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_ok |=> irq_flag);

    // R10: write-one clear without a match
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !match_ok) |=> !irq_flag);

    // R11: no pin drive while the direction bit selects input
    always_comb begin
        if (rst_n) begin
            a_r11_pin_gate: assert (port_dir || !pin_out);
        end
    end

endmodule

bind ocu_compare_channel ocu_compare_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .count_wr  (count_wr),
    .flag_clr  (flag_clr),
    .wave_mode (wave_mode),
    .cnt_down  (cnt_down),
    .port_dir  (port_dir),
    .pin_out   (pin_out),
    .oc_bit    (oc_bit),
    .irq_flag  (irq_flag),
    .match_ok  (match_ok),
    .om_q      (om_q)
);

// File: tb/ocu_compare_channel_test.sv
module ocu_compare_channel_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] count = '0;
    logic         count_wr = 1'b0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         om_wr = 1'b0;
    logic [1:0]   om_wdata = '0;
    logic [1:0]   wave_mode = '0;
    logic         cnt_down = 1'b0;
    logic         cnt_wrap = 1'b0;
    logic         force_strobe = 1'b0;
    logic         flag_clr = 1'b0;
    logic         port_data = 1'b0;
    logic         port_dir = 1'b0;
    logic         oc_bit;
    logic         irq_flag;
    logic         pin_out;
    logic         pin_oe;

    always #2 clk = ~clk;

    ocu_compare_channel #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .count_wr(count_wr),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .om_wr(om_wr), .om_wdata(om_wdata),
        .wave_mode(wave_mode), .cnt_down(cnt_down), .cnt_wrap(cnt_wrap),
        .force_strobe(force_strobe), .flag_clr(flag_clr), .port_data(port_data),
        .port_dir(port_dir), .oc_bit(oc_bit), .irq_flag(irq_flag),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct {
        int   req;
        logic oc;
        logic flag;
        logic pin;
        logic oe;
    } exp_t;

    exp_t sb[$];
    exp_t got;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    // reference model state, built from the requirements
    logic         m_oc = 1'b0;
    logic         m_flag = 1'b0;
    logic         m_blk = 1'b0;
    logic [W-1:0] m_cmp = '0;
    logic [1:0]   m_om = '0;

    // staged settings
    logic [1:0]   g_mode = 2'b00;
    logic         g_pdata = 1'b0;
    logic         g_pdir = 1'b0;
    logic         p_cw = 1'b0;
    logic [W-1:0] p_cmp = '0;
    logic         p_ow = 1'b0;
    logic [1:0]   p_om = '0;

    // driver: apply one cycle of stimulus and push the expected outputs
    task automatic step(input int req, input logic tk, input logic [W-1:0] cn,
                        input logic cw, input logic fr, input logic fc,
                        input logic wp, input logic dn);
        logic mt;
        logic nxt;
        exp_t e;
        @(negedge clk);
        tick = tk; count = cn; count_wr = cw; force_strobe = fr; flag_clr = fc;
        cnt_wrap = wp; cnt_down = dn; wave_mode = g_mode;
        port_data = g_pdata; port_dir = g_pdir;
        cmp_wr = p_cw; cmp_wdata = p_cmp; om_wr = p_ow; om_wdata = p_om;
        mt  = tk && (cn == m_cmp) && !m_blk && !cw;
        nxt = m_oc;
        if (m_om != 2'b00) begin
            if (g_mode == 2'b01) begin
                if (m_om != 2'b01) begin
                    if (tk && wp)  nxt = (m_om == 2'b10);
                    else if (mt)   nxt = (m_om == 2'b11);
                end
            end else if (g_mode == 2'b10) begin
                if (mt && m_om != 2'b01) nxt = (m_om == 2'b10) ? dn : !dn;
            end else begin
                if (mt || fr) nxt = (m_om == 2'b01) ? !m_oc : (m_om == 2'b11);
            end
        end
        m_oc   = nxt;
        m_flag = mt ? 1'b1 : (fc ? 1'b0 : m_flag);
        m_blk  = cw ? 1'b1 : (tk ? 1'b0 : m_blk);
        if (p_cw) m_cmp = p_cmp;
        if (p_ow) m_om = p_om;
        p_cw = 1'b0;
        p_ow = 1'b0;
        e.req  = req;
        e.oc   = m_oc;
        e.flag = m_flag;
        e.oe   = g_pdir;
        e.pin  = g_pdir & ((m_om != 2'b00) ? m_oc : g_pdata);
        sb.push_back(e);
    endtask

    task automatic idle(input int req);
        step(req, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic tk(input int req, input logic [W-1:0] c);
        step(req, 1'b1, c, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic clr_flag(input int req);
        step(req, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic set_cmp(input int req, input logic [W-1:0] v);
        p_cw = 1'b1; p_cmp = v;
        idle(req);
    endtask

    task automatic set_om(input int req, input logic [1:0] v);
        p_ow = 1'b1; p_om = v;
        idle(req);
    endtask

    // monitor: compare outputs after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb.size() > 0) begin
                got = sb.pop_front();
                total++;
                if (oc_bit !== got.oc || irq_flag !== got.flag ||
                    pin_out !== got.pin || pin_oe !== got.oe) begin
                    bad++;
                    $display("FAIL R%0d actual oc=%b flag=%b pin=%b oe=%b expected oc=%b flag=%b pin=%b oe=%b",
                             got.req, oc_bit, irq_flag, pin_out, pin_oe,
                             got.oc, got.flag, got.pin, got.oe);
                end
            end
        end
    end

    initial begin
        #80000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle(1);
        idle(1);

        // R4: non-PWM toggle; R9: flag at the match edge
        g_mode = 2'b00;
        set_cmp(12, 16'd5);
        set_om(12, 2'b01);
        tk(4, 16'd3);
        tk(4, 16'd4);
        tk(9, 16'd5);
        tk(4, 16'd6);

        // R10: write-one clear
        clr_flag(10);
        // R9: set beats clear in the same cycle
        step(9, 1'b1, 16'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        clr_flag(10);

        // R4 / R12: set then clear, action field effective next cycle
        set_om(12, 2'b11);
        tk(4, 16'd5);
        set_om(12, 2'b10);
        tk(4, 16'd5);
        clr_flag(10);

        // R4: mode code 11 is also non-PWM
        g_mode = 2'b11;
        set_om(4, 2'b01);
        tk(4, 16'd5);
        tk(4, 16'd5);
        clr_flag(10);
        g_mode = 2'b00;

        // R5: force strobe toggles without a match and leaves the flag clear
        step(5, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step(5, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        set_om(5, 2'b11);
        step(5, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R5: strobe ignored in PWM families
        set_om(5, 2'b10);
        g_mode = 2'b01;
        step(5, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        g_mode = 2'b10;
        step(5, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R1: level kept across mode changes
        g_mode = 2'b00;
        idle(1);

        // R2: count write while stopped blocks the next ticked match
        set_om(2, 2'b01);
        set_cmp(2, 16'd7);
        step(2, 1'b0, 16'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        idle(2);
        idle(2);
        tk(2, 16'd7);
        tk(2, 16'd8);
        tk(2, 16'd7);
        clr_flag(10);
        // R2: write together with a matching tick
        step(2, 1'b1, 16'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        tk(2, 16'd7);
        tk(2, 16'd7);
        clr_flag(10);

        // R3: action 00 holds the level in every family
        set_om(3, 2'b00);
        for (int m = 0; m < 3; m++) begin
            g_mode = m[1:0];
            tk(3, 16'd7);
            step(3, 1'b1, 16'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            step(3, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        end
        clr_flag(10);

        // R6: single-slope, TOP = 3, compare 1, both polarities
        g_mode = 2'b01;
        set_cmp(6, 16'd1);
        set_om(6, 2'b10);
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 4; c++)
                step(6, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, (c == 3), 1'b0);
        set_om(6, 2'b11);
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 4; c++)
                step(6, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, (c == 3), 1'b0);

        // R13: action 01 inert in single-slope
        set_om(13, 2'b01);
        for (int c = 0; c < 4; c++)
            step(13, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, (c == 3), 1'b0);

        // R7: compare at TOP holds high, compare 0 gives a one-tick pulse
        set_om(7, 2'b10);
        set_cmp(7, 16'd3);
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 4; c++)
                step(7, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, (c == 3), 1'b0);
        set_cmp(7, 16'd0);
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 4; c++)
                step(7, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, (c == 3), 1'b0);

        // R8: dual-slope, compare 2, up 0..3 then down 2..1
        g_mode = 2'b10;
        set_cmp(8, 16'd2);
        set_om(8, 2'b10);
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 4; c++) step(8, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            for (int c = 2; c > 0; c--) step(8, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        end
        set_om(8, 2'b11);
        for (int c = 0; c < 4; c++) step(8, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int c = 2; c > 0; c--) step(8, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        // R13: action 01 inert in dual-slope
        set_om(13, 2'b01);
        for (int c = 0; c < 4; c++) step(13, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int c = 2; c > 0; c--) step(13, 1'b1, W'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

        // R11: pin source and direction gating
        g_mode = 2'b00;
        set_om(11, 2'b00);
        g_pdata = 1'b1; g_pdir = 1'b1;
        idle(11);
        g_pdir = 1'b0;
        idle(11);
        g_pdir = 1'b1;
        set_om(11, 2'b11);
        tk(11, 16'd2);
        g_pdata = 1'b0;
        set_om(11, 2'b10);
        tk(11, 16'd2);
        g_pdata = 1'b1;
        idle(11);
        g_pdir = 1'b0;
        idle(11);

        idle(1);
        wait (sb.size() == 0);
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule